// File: doc/BRIEF.md
# Prioritized ADC Interrupt Vector Generator

This block collects the interrupt events of an analog-to-digital converter controller into eighteen sticky flags. Two of them are overflow events: a result was overwritten before it was read, or a new conversion was requested before the previous one finished. The other sixteen are conversion-complete events, one per channel. The block encodes the highest-priority pending flag as a single even-numbered vector word. An interrupt handler can use that word directly as a jump offset.

Each kind of flag is cleared in its own way. Reading the vector word acknowledges only the two overflow flags. The overflow flags have no other software access, so the vector word is the only way to see them. A channel flag clears when software writes its bit or when the result memory of that channel is read. The vector word is read-only. A write to it throws away whichever event is currently on top, whatever its type. A request line is high while anything is pending.

Top module: `adc_irq_vector`

## Requirements
- R1: Priority runs, from highest to lowest, as result-overflow, then conversion-time-overflow, then channel flags 0 up to 15. The vector word always reports the highest pending flag.
- R2: The vector word is 0 when no flag is pending. It is 2 for result-overflow, 4 for time-overflow, and 6 + 2·n for channel flag n, so channel 15 gives 36.
- R3: A vector read strobe acknowledges the top flag when that flag is one of the two overflow flags. The flag is gone from the vector word after the next clock edge.
- R4: With both overflow flags pending, successive reads return 2 and then 4, and after that the next lower source or 0. If result-overflow is set again between the reads, the second read returns 2 again.
- R5: A vector read strobe never clears a channel flag. The vector word is unchanged after such a read.
- R6: A software write loads all sixteen channel flags from its data, with bit n for channel n. A 0 clears the flag and a 1 sets it. A result-memory read strobe on bit n clears channel flag n.
- R7: A vector write strobe clears whichever flag is currently the highest pending one, overflow or channel. The next pending source then appears on the vector word.
- R8: When a set pulse and any clear request reach the same flag in the same cycle, the flag stays set.
- R9: The request output is high exactly when the vector word is nonzero. Bit 0 and bits 15 to 6 of the vector word are always 0.
- R10: A synchronous active-high reset clears all eighteen flags. The vector word then reads 0 and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_set | input | 1 | Set pulse for the result-overflow flag |
| tov_set | input | 1 | Set pulse for the conversion-time-overflow flag |
| chan_set | input | 16 | Set pulses for the channel-complete flags, bit n for channel n |
| vec_rd | input | 1 | Read strobe of the vector word |
| vec_wr | input | 1 | Write strobe of the vector word (discards the top event) |
| mem_rd | input | 16 | Result-memory read strobes, bit n clears channel flag n |
| sw_wr_en | input | 1 | Software write strobe for the channel flags |
| sw_wr_data | input | 16 | Data loaded into the channel flags on a software write |
| vec_word | output | 16 | Vector word of the highest pending flag |
| irq | output | 1 | High while any flag is pending |

## Verification
The priority encoder is driven with single-source patterns, which pin down the code of each position. It is also driven with patterns where every source is set at once and where two distant channels are set together. Those show that the lowest-index flag wins and not some other bit. Clearing is tried with the vector read, the vector write, a software write and a result-memory read, each against a mix of overflow and channel flags. This separates the acknowledge that touches only overflow flags from the one that touches anything. Set pulses are placed in the same cycle as each kind of clear to show that the set takes precedence.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
    // Positions of the fixed sources in the pending vector; channels follow.
    localparam int unsigned SRC_OVF    = 0;
    localparam int unsigned SRC_TOV    = 1;
    localparam int unsigned FIXED_SRCS = 2;
    // Spacing between consecutive vector codes.
    localparam int unsigned CODE_STEP  = 2;
endpackage

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
    parameter int unsigned NUM_SRC = 18,
    parameter int unsigned VEC_W   = 16
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] grant,
    output logic [VEC_W-1:0]   code,
    output logic               any_pend
);
    import ivg_pkg::*;

    // Chain of "some higher-priority source is pending" terms.
    logic [NUM_SRC:0] above;

    assign above[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign above[i+1] = above[i] | pend[i];
        assign grant[i]   = pend[i] & ~above[i];
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                code = VEC_W'((i + 1) * CODE_STEP);
            end
        end
    end

    assign any_pend = above[NUM_SRC];
endmodule

// File: rtl/ivg_flag_bank.sv
module ivg_flag_bank #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ovf_set,
    input  logic              tov_set,
    input  logic [NUM_CH-1:0] chan_set,
    input  logic              vec_rd,
    input  logic              vec_wr,
    input  logic [NUM_CH+1:0] grant,
    input  logic [NUM_CH-1:0] mem_rd,
    input  logic              sw_wr_en,
    input  logic [NUM_CH-1:0] sw_wr_data,
    output logic [NUM_CH+1:0] pend
);
    import ivg_pkg::*;

    localparam int unsigned NUM_SRC = NUM_CH + FIXED_SRCS;

    typedef struct packed {
        logic [NUM_CH-1:0] chan;
        logic              tov;
        logic              ovf;
    } flags_t;

    flags_t flags_d, flags_q;

    always_comb begin
        logic [NUM_SRC-1:0] ack;
        logic [NUM_CH-1:0]  base;

        // Write discards any top source; read acknowledges overflow only.
        ack = '0;
        if (vec_wr) begin
            ack = grant;
        end else if (vec_rd) begin
            ack[SRC_OVF] = grant[SRC_OVF];
            ack[SRC_TOV] = grant[SRC_TOV];
        end

        base = sw_wr_en ? sw_wr_data : flags_q.chan;

        flags_d      = flags_q;
        flags_d.ovf  = (flags_q.ovf & ~ack[SRC_OVF]) | ovf_set;
        flags_d.tov  = (flags_q.tov & ~ack[SRC_TOV]) | tov_set;
        flags_d.chan = (base & ~mem_rd & ~ack[NUM_SRC-1:FIXED_SRCS]) | chan_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign pend = flags_q;
endmodule

// File: rtl/adc_irq_vector.sv
module adc_irq_vector #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned VEC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ovf_set,
    input  logic              tov_set,
    input  logic [NUM_CH-1:0] chan_set,
    input  logic              vec_rd,
    input  logic              vec_wr,
    input  logic [NUM_CH-1:0] mem_rd,
    input  logic              sw_wr_en,
    input  logic [NUM_CH-1:0] sw_wr_data,
    output logic [VEC_W-1:0]  vec_word,
    output logic              irq
);
    import ivg_pkg::*;

    localparam int unsigned NUM_SRC = NUM_CH + FIXED_SRCS;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;

    ivg_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .ovf_set    (ovf_set),
        .tov_set    (tov_set),
        .chan_set   (chan_set),
        .vec_rd     (vec_rd),
        .vec_wr     (vec_wr),
        .grant      (grant),
        .mem_rd     (mem_rd),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .pend       (pend)
    );

    ivg_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
        .pend     (pend),
        .grant    (grant),
        .code     (vec_word),
        .any_pend (irq)
    );
endmodule

// File: rtl/adc_irq_vector_chk.sv
module adc_irq_vector_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned VEC_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ovf_set,
    input logic              tov_set,
    input logic [NUM_CH-1:0] chan_set,
    input logic              vec_rd,
    input logic              vec_wr,
    input logic [NUM_CH-1:0] mem_rd,
    input logic              sw_wr_en,
    input logic [NUM_CH-1:0] sw_wr_data,
    input logic [VEC_W-1:0]  vec_word,
    input logic              irq
);
    logic quiet;
    assign quiet = !ovf_set && !tov_set && (chan_set == '0) && !sw_wr_en
                   && (mem_rd == '0) && (sw_wr_data == sw_wr_data);

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (vec_word != '0));

    // R9
    even_code_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_word[0] && (vec_word >> 6) == '0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (vec_word == '0));

    // R8
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> (vec_word == VEC_W'(2)));

    // R3
    ovf_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && vec_word == VEC_W'(2) && !ovf_set) |=> (vec_word != VEC_W'(2)));

    // R5
    chan_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && !vec_wr && vec_word >= VEC_W'(6) && quiet) |=> $stable(vec_word));

    // R7
    wr_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_wr && vec_word != '0 && quiet) |=> (vec_word != $past(vec_word)));
endmodule

bind adc_irq_vector adc_irq_vector_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ovf_set    (ovf_set),
    .tov_set    (tov_set),
    .chan_set   (chan_set),
    .vec_rd     (vec_rd),
    .vec_wr     (vec_wr),
    .mem_rd     (mem_rd),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .vec_word   (vec_word),
    .irq        (irq)
);

// File: tb/sim_adc_irq_vector.sv
module sim_adc_irq_vector;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ovf_set, tov_set, vec_rd, vec_wr, sw_wr_en;
    logic [15:0] chan_set, mem_rd, sw_wr_data;
    logic [15:0] vec_word;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // {ovf_set, tov_set, chan_set, expected vector}
    localparam logic [33:0] TBL [NVEC] = '{
        {1'b0, 1'b0, 16'h0000, 16'd0},
        {1'b1, 1'b0, 16'h0000, 16'd2},
        {1'b0, 1'b1, 16'h0000, 16'd4},
        {1'b1, 1'b1, 16'hFFFF, 16'd2},
        {1'b0, 1'b1, 16'hFFFF, 16'd4},
        {1'b0, 1'b0, 16'h0001, 16'd6},
        {1'b0, 1'b0, 16'h8000, 16'd36},
        {1'b0, 1'b0, 16'h8010, 16'd14},
        {1'b0, 1'b0, 16'h0C00, 16'd26},
        {1'b0, 1'b0, 16'h0100, 16'd22}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_irq_vector u0 (
        .clk(clk), .rst(rst), .ovf_set(ovf_set), .tov_set(tov_set),
        .chan_set(chan_set), .vec_rd(vec_rd), .vec_wr(vec_wr), .mem_rd(mem_rd),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .vec_word(vec_word), .irq(irq)
    );

    task automatic idle_inputs();
        ovf_set = 0; tov_set = 0; chan_set = '0; vec_rd = 0; vec_wr = 0;
        mem_rd = '0; sw_wr_en = 0; sw_wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic chk(string req, logic [15:0] exp);
        checks++;
        if (vec_word !== exp || irq !== (exp != 0) || vec_word[0] !== 1'b0
            || vec_word[15:6] !== '0) begin
            errors++;
            $display("FAIL %s: vector=%0d irq=%b expected vector=%0d irq=%b",
                     req, vec_word, irq, exp, exp != 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        do_reset();
        chk("R10 reset state", 16'd0);

        // R1 R2 R9: table of single and mixed source patterns
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            ovf_set  = TBL[i][33];
            tov_set  = TBL[i][32];
            chan_set = TBL[i][31:16];
            step();
            chk("R1/R2/R9 table", TBL[i][15:0]);
        end

        // R3 R4: both overflow flags acknowledged in turn
        do_reset();
        ovf_set = 1; tov_set = 1; chan_set = 16'h0004; step();
        chk("R4 both pending", 16'd2);
        vec_rd = 1; step();
        chk("R3 first read leaves time overflow", 16'd4);
        vec_rd = 1; step();
        chk("R4 second read exposes channel 2", 16'd10);

        // R8 R4: overflow set again in the cycle of its read
        do_reset();
        ovf_set = 1; tov_set = 1; step();
        vec_rd = 1; ovf_set = 1; step();
        chk("R8 set beats read clear", 16'd2);
        vec_rd = 1; step();
        chk("R4 read after reassert", 16'd4);
        ovf_set = 1; step();
        chk("R4 overflow set between reads", 16'd2);

        // R5: read leaves channel flag in place
        do_reset();
        chan_set = 16'h0008; step();
        vec_rd = 1; step();
        chk("R5 read keeps channel 3", 16'd12);

        // R6: result-memory read and software write
        mem_rd = 16'h0008; step();
        chk("R6 memory read clears channel 3", 16'd0);
        sw_wr_en = 1; sw_wr_data = 16'h0020; step();
        chk("R6 software write sets channel 5", 16'd16);
        sw_wr_en = 1; sw_wr_data = 16'h0000; step();
        chk("R6 software write of zero clears", 16'd0);

        // R7: write discards top source of any type
        do_reset();
        chan_set = 16'h0084; step();
        vec_wr = 1; step();
        chk("R7 write drops channel 2", 16'd20);
        ovf_set = 1; tov_set = 1; step();
        vec_wr = 1; step();
        chk("R7 write drops overflow", 16'd4);

        // R8: set beats memory-read clear and write discard
        do_reset();
        chan_set = 16'h0010; step();
        mem_rd = 16'h0010; chan_set = 16'h0010; step();
        chk("R8 set beats memory read", 16'd14);
        vec_wr = 1; chan_set = 16'h0010; step();
        chk("R8 set beats vector write", 16'd14);

        // R10: reset with flags pending
        ovf_set = 1; chan_set = 16'hFFFF; step();
        do_reset();
        chk("R10 reset clears pending flags", 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule